// File: doc/BRIEF.md
# Two-Wire Slave Register Access Port

This block is the serial front end of a small timekeeping device. It sits on a two-wire bus, using the open-drain I2C style with one clock line and one data line. It lets a bus master read or write one byte of the device's register space per transfer. The register space has two banks. The timekeeping bank holds the calendar fields, a control byte and a century byte. The scratch bank is a 31-byte SRAM. The storage itself is outside the block. The block presents a one-cycle read or write strobe together with a bank select, an index and write data, and it takes read data back combinationally.

Each transfer is framed by a START and a STOP. It carries three bytes, in this order. The first is a device-ID byte: a 7-bit device address followed by a direction bit. The second is a command byte, always sent by the master, which picks the bank and the index. The third is one data byte, which flows from the master on a write and from the slave on a read. The block never answers the all-zero broadcast address. It never drives the data line high: its only output toward the bus is a pull-low enable. Both bus lines must already be synchronized to `clk` before they reach the block.

Top module: `i2c_regs_slave`

## Requirements
- R1: After reset, and after any STOP, the pull-low enable is 0 and no read or write strobe is raised until a START is seen (SDA falling while SCL is high).
- R2: Bits are sampled on SCL rising edges, MSB first. If the upper 7 bits of the first byte equal `dev_addr_i`, the slave pulls SDA low for the whole ninth clock. Bit 0 of that byte selects the direction: 1 means read.
- R3: If the first byte does not match, the slave acknowledges nothing and accesses nothing until the next START.
- R4: A first byte whose address bits are all zero is never acknowledged, even when `dev_addr_i` is 0.
- R5: The second byte is always acknowledged after a match. Its bit 6 selects the bank (0 = timekeeping, 1 = scratch) and its bits 4:0 give the index. Bits 7 and 5 are ignored.
- R6: On a write, the data byte is acknowledged. `reg_we_o` pulses for exactly one cycle, carrying the bank, the index and the full byte. It is never high in the same cycle as `reg_re_o`.
- R7: On a read, `reg_re_o` pulses once and the slave shifts the addressed byte out MSB first. The pull-low enable changes only while SCL is low.
- R8: After the eighth data bit of a read, the slave releases SDA and drives nothing more, whatever the master answers, until the next START.
- R9: An index that is out of range (timekeeping index of 10 or more, scratch index of 31) is still acknowledged. A write to it raises no strobe. A read of it raises no strobe and returns 0xFF.
- R10: A START or a STOP in the middle of a byte abandons the transfer with no write. A START restarts reception at the first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| dev_addr_i | input | 7 | Fixed device address |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| reg_bank_o | output | 1 | 0 = timekeeping bank, 1 = scratch bank |
| reg_idx_o | output | IDX_W | Register index |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data for the selected bank and index |

## Verification
Suppose the bit counter or the transfer phase goes wrong. The fault shows at the ninth SCL clock of the byte concerned: an acknowledge is missing, a stray one appears, or the data shifted out is displaced by one bit. So a bad phase is visible within one byte time on the bus. Suppose instead the command latch or the range check is wrong. That shows only when the strobe fires: a bad index or bank on the register port, a write that should not happen, or a 0xFF read from a valid location. Every transfer is therefore checked twice: once at the bus for acknowledges and data, and once against a model of the register storage that the strobes update.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ID,
    PH_CMD,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;

  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cs_idx_range.sv
module i2cs_idx_range #(
  parameter int CLK_REGS   = 10,
  parameter int SRAM_WORDS = 31,
  parameter int IDX_W      = 5
) (
  input  logic             bank_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             valid_o
);
  logic clk_ok, sram_ok;

  generate
    if (CLK_REGS >= (1 << IDX_W)) begin : g_clk_full
      assign clk_ok = 1'b1;
    end else begin : g_clk_lim
      assign clk_ok = (idx_i < IDX_W'(CLK_REGS));
    end
    if (SRAM_WORDS >= (1 << IDX_W)) begin : g_sram_full
      assign sram_ok = 1'b1;
    end else begin : g_sram_lim
      assign sram_ok = (idx_i < IDX_W'(SRAM_WORDS));
    end
  endgenerate

  assign valid_o = bank_i ? sram_ok : clk_ok;
endmodule

// File: rtl/i2c_regs_slave.sv
module i2c_regs_slave #(
  parameter int CLK_REGS   = 10,
  parameter int SRAM_WORDS = 31,
  parameter int IDX_W      = 5,
  parameter int BANK_BIT   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [6:0]       dev_addr_i,
  output logic             sda_oe_o,
  output logic             reg_bank_o,
  output logic [IDX_W-1:0] reg_idx_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_we_o,
  output logic             reg_re_o,
  input  logic [7:0]       reg_rdata_i
);
  import i2cs_pkg::*;

  localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

  // reset: asserted asynchronously, released on clk
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic scl_rise, scl_fall, cond_start, cond_stop;

  i2cs_bus_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_s),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (cond_start),
    .stop_o     (cond_stop)
  );

  phase_t     ph_q, ph_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] cmd_q, cmd_d;
  logic       ack_q, ack_d;
  logic       oe_q, oe_d;
  logic       rd_q, rd_d;
  logic       we_q, we_d;
  logic       re_q, re_d;
  logic       idx_ok;
  logic       id_hit;

  i2cs_idx_range #(
    .CLK_REGS   (CLK_REGS),
    .SRAM_WORDS (SRAM_WORDS),
    .IDX_W      (IDX_W)
  ) u_range (
    .bank_i  (cmd_q[BANK_BIT]),
    .idx_i   (cmd_q[IDX_W-1:0]),
    .valid_o (idx_ok)
  );

  assign id_hit = (sh_q[7:1] == dev_addr_i) && (sh_q[7:1] != 7'd0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    cmd_d = cmd_q;
    ack_d = ack_q;
    oe_d  = oe_q;
    rd_d  = rd_q;
    we_d  = 1'b0;
    re_d  = 1'b0;
    if (cond_stop) begin
      ph_d  = PH_IDLE;
      cnt_d = 4'd0;
      ack_d = 1'b0;
      oe_d  = 1'b0;
    end else if (cond_start) begin
      ph_d  = PH_ID;
      cnt_d = 4'd0;
      ack_d = 1'b0;
      oe_d  = 1'b0;
    end else begin
      unique case (ph_q)
        PH_ID, PH_CMD, PH_WDATA: begin
          if (scl_rise && cnt_q < LAST_BIT) begin
            sh_d  = {sh_q[6:0], sda_i};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && ack_q) begin
            // end of the ninth clock: release and move on
            ack_d = 1'b0;
            oe_d  = 1'b0;
            cnt_d = 4'd0;
            if (ph_q == PH_ID) begin
              ph_d = PH_CMD;
            end else if (ph_q == PH_CMD) begin
              if (rd_q) begin
                ph_d = PH_RDATA;
                re_d = idx_ok;
                sh_d = idx_ok ? reg_rdata_i : 8'hFF;
                oe_d = idx_ok & ~reg_rdata_i[7];
              end else begin
                ph_d = PH_WDATA;
              end
            end else begin
              ph_d = PH_SKIP;
            end
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (ph_q == PH_ID) begin
              if (id_hit) begin
                ack_d = 1'b1;
                oe_d  = 1'b1;
                rd_d  = sh_q[0];
              end else begin
                ph_d = PH_SKIP;
              end
            end else begin
              ack_d = 1'b1;
              oe_d  = 1'b1;
              if (ph_q == PH_CMD) cmd_d = sh_q;
              else                we_d  = idx_ok;
            end
          end
        end
        PH_RDATA: begin
          if (scl_rise && cnt_q < LAST_BIT) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (ack_q) begin
              ph_d  = PH_SKIP;
              ack_d = 1'b0;
            end else if (cnt_q == LAST_BIT) begin
              oe_d  = 1'b0;
              ack_d = 1'b1;
            end else if (cnt_q != 4'd0) begin
              sh_d = {sh_q[6:0], 1'b1};
              oe_d = ~sh_q[6];
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ph_q  <= PH_IDLE;
      cnt_q <= 4'd0;
      sh_q  <= 8'd0;
      cmd_q <= 8'd0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
      rd_q  <= 1'b0;
      we_q  <= 1'b0;
      re_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      cmd_q <= cmd_d;
      ack_q <= ack_d;
      oe_q  <= oe_d;
      rd_q  <= rd_d;
      we_q  <= we_d;
      re_q  <= re_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_bank_o  = cmd_q[BANK_BIT];
  assign reg_idx_o   = cmd_q[IDX_W-1:0];
  assign reg_wdata_o = sh_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
  parameter int CLK_REGS   = 10,
  parameter int SRAM_WORDS = 31,
  parameter int IDX_W      = 5
) (
  input logic             clk,
  input logic             rst_s,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             reg_bank_o,
  input logic [IDX_W-1:0] reg_idx_o,
  input logic             reg_we_o,
  input logic             reg_re_o
);
  // R6: single-cycle write strobe
  p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rst_s)
    reg_we_o |=> !reg_we_o);

  // R6: never read and write together
  p_we_re_excl_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !(reg_we_o && reg_re_o));

  // R9: write strobe only to an existing location
  p_we_in_range_r9: assert property (@(posedge clk) disable iff (!rst_s)
    reg_we_o |-> (reg_bank_o ? (int'(reg_idx_o) < SRAM_WORDS)
                             : (int'(reg_idx_o) < CLK_REGS)));

  // R9: read strobe only to an existing location
  p_re_in_range_r9: assert property (@(posedge clk) disable iff (!rst_s)
    reg_re_o |-> (reg_bank_o ? (int'(reg_idx_o) < SRAM_WORDS)
                             : (int'(reg_idx_o) < CLK_REGS)));

  // R7: data line drive changes only while SCL is low
  p_oe_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  // R7: read strobe is a single pulse
  p_re_pulse_r7: assert property (@(posedge clk) disable iff (!rst_s)
    reg_re_o |=> !reg_re_o);
endmodule

bind i2c_regs_slave i2cs_chk #(
  .CLK_REGS   (CLK_REGS),
  .SRAM_WORDS (SRAM_WORDS),
  .IDX_W      (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .reg_bank_o (reg_bank_o),
  .reg_idx_o  (reg_idx_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o)
);

// File: tb/tb_i2c_regs_slave.sv
module tb_i2c_regs_slave;
  localparam int CLK_REGS = 10;
  localparam int SRAM_WORDS = 31;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_bus;
  logic [6:0] dev_addr;
  logic sda_oe, bank, we, re;
  logic [4:0] idx;
  logic [7:0] wdata, rdata;

  logic [7:0] m_clk [CLK_REGS];
  logic [7:0] m_sram[SRAM_WORDS];
  logic [7:0] e_clk [CLK_REGS];
  logic [7:0] e_sram[SRAM_WORDS];
  int we_cnt, re_cnt, n_chk, n_err;
  logic [7:0] last_wd;
  logic [4:0] last_idx;
  logic last_bank;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_regs_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .dev_addr_i(dev_addr), .sda_oe_o(sda_oe), .reg_bank_o(bank),
    .reg_idx_o(idx), .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re),
    .reg_rdata_i(rdata)
  );

  always_comb begin
    if (bank) rdata = (int'(idx) < SRAM_WORDS) ? m_sram[idx] : 8'h00;
    else      rdata = (int'(idx) < CLK_REGS) ? m_clk[idx] : 8'h00;
  end

  always @(posedge clk) begin
    if (we) begin
      we_cnt <= we_cnt + 1;
      last_wd <= wdata; last_idx <= idx; last_bank <= bank;
      if (bank && int'(idx) < SRAM_WORDS) m_sram[idx] <= wdata;
      else if (!bank && int'(idx) < CLK_REGS) m_clk[idx] <= wdata;
    end
    if (re) re_cnt <= re_cnt + 1;
  end

  function automatic bit idx_valid(input logic [7:0] cmd);
    return cmd[6] ? (int'(cmd[4:0]) < SRAM_WORDS) : (int'(cmd[4:0]) < CLK_REGS);
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] cmd);
    if (!idx_valid(cmd)) return 8'hFF;
    return cmd[6] ? e_sram[cmd[4:0]] : e_clk[cmd[4:0]];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_bus}; tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = mack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd,
                          input logic [7:0] d, output bit k1, output bit k2, output bit k3);
    bus_start;
    send_byte({a, 1'b0}, k1);
    send_byte(cmd, k2);
    send_byte(d, k3);
    bus_stop;
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] cmd,
                         output bit k1, output bit k2, output logic [7:0] d);
    bus_start;
    send_byte({a, 1'b1}, k1);
    send_byte(cmd, k2);
    recv_byte(1'b0, d);
    bus_stop;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run;
  end

  initial begin
    bit k1, k2, k3;
    logic [7:0] d, cmd, dat;
    int w0, r0, seed_dummy;
    seed_dummy = $urandom(32'd1234);
    n_chk = 0; n_err = 0; we_cnt = 0; re_cnt = 0;
    for (int i = 0; i < CLK_REGS; i++) begin m_clk[i] = 8'h00; e_clk[i] = 8'h00; end
    for (int i = 0; i < SRAM_WORDS; i++) begin m_sram[i] = 8'h00; e_sram[i] = 8'h00; end
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; dev_addr = 7'h52;
    tick(5); rst_n = 1'b1; tick(5);

    // R1: quiet after reset
    chk("R1 oe after reset", sda_oe, 0);
    chk("R1 strobes after reset", we_cnt + re_cnt, 0);

    // R2 R5 R6: write timekeeping index 3
    do_write(7'h52, 8'h03, 8'hA5, k1, k2, k3);
    e_clk[3] = 8'hA5;
    chk("R2 id ack", k1, 1);
    chk("R5 cmd ack", k2, 1);
    chk("R6 data ack", k3, 1);
    chk("R6 one write", we_cnt, 1);
    chk("R6 write fields", {last_bank, last_idx, last_wd}, {1'b0, 5'd3, 8'hA5});
    chk("R1 oe after stop", sda_oe, 0);

    // R7 R8: read it back; ignored cmd bits 7 and 5 set (R5)
    do_read(7'h52, 8'hA3, k1, k2, d);
    chk("R7 read data", d, 8'hA5);
    chk("R7 one read strobe", re_cnt, 1);
    chk("R8 released after read", sda_oe, 0);

    // R5: scratch bank last word
    do_write(7'h52, 8'h5E, 8'h69, k1, k2, k3);
    e_sram[30] = 8'h69;
    do_read(7'h52, 8'h5E, k1, k2, d);
    chk("R5 scratch read", d, 8'h69);

    // R3: address mismatch
    w0 = we_cnt;
    do_write(7'h11, 8'h01, 8'h77, k1, k2, k3);
    chk("R3 no id ack", k1, 0);
    chk("R3 no cmd ack", k2, 0);
    chk("R3 no write", we_cnt, w0);

    // R4: broadcast address with device address 0
    dev_addr = 7'h00;
    do_write(7'h00, 8'h01, 8'h77, k1, k2, k3);
    chk("R4 no broadcast ack", k1, 0);
    chk("R4 no write", we_cnt, w0);
    dev_addr = 7'h52;

    // R9: out-of-range write and read
    do_write(7'h52, 8'h0C, 8'h12, k1, k2, k3);
    chk("R9 cmd ack", k2, 1);
    chk("R9 data ack", k3, 1);
    chk("R9 no write", we_cnt, w0);
    r0 = re_cnt;
    do_read(7'h52, 8'h5F, k1, k2, d);
    chk("R9 read FF", d, 8'hFF);
    chk("R9 no read strobe", re_cnt, r0);

    // R8: master ACKs and clocks another byte
    bus_start;
    send_byte({7'h52, 1'b1}, k1);
    send_byte(8'h03, k2);
    recv_byte(1'b1, d);
    chk("R8 first byte", d, 8'hA5);
    recv_byte(1'b0, d);
    chk("R8 extra byte released", d, 8'hFF);
    bus_stop;

    // R10: START mid data byte, then full transfer
    w0 = we_cnt;
    bus_start;
    send_byte({7'h52, 1'b0}, k1);
    send_byte(8'h45, k2);
    send_bits(8'hF0, 4);
    bus_start;
    chk("R10 no write on restart", we_cnt, w0);
    send_byte({7'h52, 1'b0}, k1);
    send_byte(8'h45, k2);
    send_byte(8'h3C, k3);
    bus_stop;
    e_sram[5] = 8'h3C;
    chk("R10 restart write", we_cnt, w0 + 1);
    chk("R10 restart data", last_wd, 8'h3C);

    // R10: STOP mid data byte
    bus_start;
    send_byte({7'h52, 1'b0}, k1);
    send_byte(8'h45, k2);
    send_bits(8'h81, 3);
    bus_stop;
    chk("R10 no write on stop", we_cnt, w0 + 1);

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [6:0] a;
      bit op, hit;
      a = ($urandom % 8 == 0) ? 7'h33 : 7'h52;
      hit = (a == 7'h52);
      cmd = {1'b0, 1'($urandom), 1'b0, 5'($urandom)};
      dat = 8'($urandom);
      op = 1'($urandom);
      if (op) begin
        do_write(a, cmd, dat, k1, k2, k3);
        chk("R2 rand id ack", k1, int'(hit));
        chk("R6 rand data ack", k3, int'(hit));
        if (hit && idx_valid(cmd)) begin
          if (cmd[6]) e_sram[cmd[4:0]] = dat; else e_clk[cmd[4:0]] = dat;
        end
      end else begin
        do_read(a, cmd, k1, k2, d);
        chk("R2 rand id ack", k1, int'(hit));
        chk("R7 rand read", d, hit ? int'(exp_read(cmd)) : 8'hFF);
      end
    end

    for (int i = 0; i < CLK_REGS; i++) chk("R6 final timekeeping", m_clk[i], e_clk[i]);
    for (int i = 0; i < SRAM_WORDS; i++) chk("R6 final scratch", m_sram[i], e_sram[i]);

    finish_run;
  end
endmodule